// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs single read or write transfers on a narrow bus. The low address bits and the data share one set of lines. A requester presents a command: direction, memory or I/O space, a full address and write data. It raises a request while the sequencer is idle. The sequencer then steps through four bus phases. In the first phase it drives the low address onto the shared lines and pulses an address strobe. An internal register catches the full address on that strobe, so the rest of the system sees a stable address for the whole transfer.

In the middle phases the read or write strobe and the transceiver enable are active. On a write, the write data is driven onto the shared lines. A slow device holds the ready input low to stretch the transfer. Each sampled-low ready inserts one wait phase. If ready stays low for too many wait phases, the cycle is cut short and an error flag is raised. For a read, the shared lines are captured at the end of the last active phase. The final phase returns every strobe to its inactive level before the sequencer goes idle again.

Top module: `mux_bus_seq`

## Requirements
- R1: During and right after reset the block is idle. `busy`, `ale`, `ad_oe`, `rdata_vld` and `timeout` are 0. `rd_n`, `wr_n` and `den_n` are 1. `dt_r` is 1, `io_m` is 0, `a_hi` is 0 and `lat_addr` and `rdata` are 0.
- R2: A request is sampled at a rising edge only while idle. The first phase (T1) follows in the next cycle. The command is captured at that edge, so later changes on the request inputs, including `req` held high, have no effect until the block is idle again.
- R3: In T1, `ale`=1, `ad_oe`=1 and `ad_out` = address bits 7:0. The strobes are all inactive. `a_hi` carries address bits 19:8 from T1 through T4 and is 0 when idle.
- R4: In T2, in every wait phase and in T3, `den_n`=0 and `ale`=0. A read drives `rd_n`=0 with `ad_oe`=0. A write drives `wr_n`=0 with `ad_oe`=1 and `ad_out` = write data.
- R5: Ready is sampled at the end of T2. If it is 1, T3 follows. If it is 0, a wait phase follows.
- R6: Ready is sampled again at the end of each wait phase. If it is 1, T3 follows. Otherwise another wait phase follows, up to MAX_WAIT (default 6) wait phases. A transfer that completes with n wait phases keeps `busy` high for 4+n cycles.
- R7: A read captures `ad_in` into `rdata` at the end of T3. `rdata_vld` is 1 for exactly the T4 cycle of a completed read. `rdata` is unchanged by writes and by aborted reads.
- R8: In T4, and while idle, `rd_n`, `wr_n` and `den_n` are 1 and `ale` and `ad_oe` are 0.
- R9: `lat_addr` loads {`a_hi`,`ad_out`} at the edge that ends an `ale` cycle and holds that value until the next `ale`.
- R10: From T1 through T4, `dt_r` is 0 for a read and 1 for a write. In the same phases, `io_m` is 1 for I/O and 0 for memory. Neither changes within a transfer.
- R11: If ready is still 0 at the end of the MAX_WAIT-th wait phase, T4 follows directly and no data is captured. `busy` is then high for MAX_WAIT+3 cycles. `timeout` goes to 1 in that T4 and stays 1 until the next request is accepted.
- R12: `busy` is 1 exactly from T1 through T4. Idle follows T4 for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a transfer (sampled while idle) |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_addr | input | AW (20) | Transfer address |
| req_wdata | input | DW (8) | Write data |
| ready | input | 1 | Synchronized device ready |
| ad_in | input | DW (8) | Shared lines as seen from the bus |
| ad_out | output | DW (8) | Value driven on the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| a_hi | output | AW-DW (12) | Upper address bits |
| lat_addr | output | AW (20) | Demultiplexed address held by the strobe register |
| ale | output | 1 | Address strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| dt_r | output | 1 | Transceiver direction: 1 transmit, 0 receive |
| io_m | output | 1 | 1 = I/O, 0 = memory |
| busy | output | 1 | Transfer in progress |
| rdata | output | DW (8) | Captured read data |
| rdata_vld | output | 1 | Read data captured this transfer (T4 only) |
| timeout | output | 1 | Last transfer was aborted on wait limit |

## Verification
The bound checker checks the following on every cycle:
- The read and write strobes are never active together.
- The direction and drive enable agree with the active strobe.
- The strobes are quiet in T4 and while idle.
- The latched address is stable outside the strobe cycle.
- The direction and space outputs hold within a transfer.
- The error flag and the read-valid pulse appear only with quiet strobes.

Some behaviour only the bench's directed and random scenarios can show:
- How many wait phases a given ready pattern produces.
- The exact boundary between MAX_WAIT wait phases and an abort.
- Which bus cycle's data lands in `rdata`.
- That a request held high during a transfer is not taken.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW       = 20,
  parameter int DW       = 8,
  parameter int MAX_WAIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_wr,
  input  logic             req_io,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic             ready,
  input  logic [DW-1:0]    ad_in,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic [AW-DW-1:0] a_hi,
  output logic [AW-1:0]    lat_addr,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             den_n,
  output logic             dt_r,
  output logic             io_m,
  output logic             busy,
  output logic [DW-1:0]    rdata,
  output logic             rdata_vld,
  output logic             timeout
);
  localparam int WCW = $clog2(MAX_WAIT + 1);
  localparam logic [WCW-1:0] WLIM = WCW'(MAX_WAIT);

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_TW, S_T3, S_T4} phase_t;

  phase_t          st;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic            wr_q, io_q;
  logic [WCW-1:0]  wcnt;
  logic            act;

  assign busy   = (st != S_IDLE);
  assign ale    = (st == S_T1);
  assign act    = (st == S_T2) || (st == S_TW) || (st == S_T3);
  assign rd_n   = !(act && !wr_q);
  assign wr_n   = !(act && wr_q);
  assign den_n  = !act;
  assign ad_oe  = ale || (act && wr_q);
  assign ad_out = ale ? addr_q[DW-1:0] : wdata_q;
  assign a_hi   = busy ? addr_q[AW-1:DW] : '0;
  assign dt_r   = busy ? wr_q : 1'b1;
  assign io_m   = busy ? io_q : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      wr_q      <= 1'b0;
      io_q      <= 1'b0;
      wcnt      <= '0;
      lat_addr  <= '0;
      rdata     <= '0;
      rdata_vld <= 1'b0;
      timeout   <= 1'b0;
    end else begin
      rdata_vld <= 1'b0;
      if (ale) lat_addr <= {a_hi, ad_out};
      case (st)
        S_IDLE: if (req) begin
          st      <= S_T1;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          wr_q    <= req_wr;
          io_q    <= req_io;
          timeout <= 1'b0;
        end
        S_T1: st <= S_T2;
        S_T2: begin
          wcnt <= WCW'(1);
          st   <= ready ? S_T3 : S_TW;
        end
        S_TW: begin
          if (ready) st <= S_T3;
          else if (wcnt == WLIM) begin
            st      <= S_T4;
            timeout <= 1'b1;
          end else wcnt <= wcnt + WCW'(1);
        end
        S_T3: begin
          st <= S_T4;
          if (!wr_q) begin
            rdata     <= ad_in;
            rdata_vld <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk #(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ad_oe,
  input logic [AW-1:0]    lat_addr,
  input logic             ale,
  input logic             rd_n,
  input logic             wr_n,
  input logic             den_n,
  input logic             dt_r,
  input logic             io_m,
  input logic             busy,
  input logic             rdata_vld,
  input logic             timeout
);
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  p_read_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !dt_r && !ad_oe && !den_n && !ale);
  p_write_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> dt_r && ad_oe && !den_n && !ale);
  p_ale_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> rd_n && wr_n && den_n && busy && ad_oe);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> rd_n && wr_n && den_n && !ale && !ad_oe);
  p_strobe_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n) || $rose(wr_n)) |-> busy && den_n && !ad_oe);
  p_after_ale_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> busy && !ale && !den_n);
  p_lat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(lat_addr));
  p_dir_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ale) |-> $stable(dt_r) && $stable(io_m));
  p_vld_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_vld |-> busy && rd_n && den_n && !dt_r && !timeout);
  p_abort_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && busy) |-> rd_n && wr_n && den_n && !ale && !rdata_vld);
endmodule

bind mux_bus_seq mux_bus_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ad_oe(ad_oe), .lat_addr(lat_addr), .ale(ale),
  .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r), .io_m(io_m),
  .busy(busy), .rdata_vld(rdata_vld), .timeout(timeout)
);

// File: tb/mux_bus_seq_tb.sv
module mux_bus_seq_tb;
  localparam int AW = 20, DW = 8, MW = 6;
  localparam int PI = 0, P1 = 1, P2 = 2, PW = 3, P3 = 4, P4 = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, req = 1'b0, req_wr = 1'b0, req_io = 1'b0, ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, ad_in = '0;
  logic [DW-1:0] ad_out, rdata;
  logic [AW-DW-1:0] a_hi;
  logic [AW-1:0] lat_addr;
  logic ad_oe, ale, rd_n, wr_n, den_n, dt_r, io_m, busy, rdata_vld, timeout;

  mux_bus_seq #(.AW(AW), .DW(DW), .MAX_WAIT(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_io(req_io),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .lat_addr(lat_addr), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r), .io_m(io_m),
    .busy(busy), .rdata(rdata), .rdata_vld(rdata_vld), .timeout(timeout));

  int n_cmp = 0, n_bad = 0;
  int ph = PI, waits = 0;
  logic [AW-1:0] m_addr = '0, m_lat = '0;
  logic [DW-1:0] m_wd = '0, m_rd = '0;
  logic m_wr = 1'b0, m_io = 1'b0, m_vld = 1'b0, m_to = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, nm, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic model_step();
    if (!rst_n) begin
      ph = PI; waits = 0; m_addr = '0; m_lat = '0; m_wd = '0; m_rd = '0;
      m_wr = 0; m_io = 0; m_vld = 0; m_to = 0;
      return;
    end
    m_vld = 0;
    case (ph)
      PI: if (req) begin
        ph = P1; m_addr = req_addr; m_wd = req_wdata; m_wr = req_wr; m_io = req_io; m_to = 0;
      end
      P1: begin m_lat = m_addr; ph = P2; end
      P2: begin waits = 0; if (ready) ph = P3; else begin waits = 1; ph = PW; end end
      PW: if (ready) ph = P3;
          else if (waits == MW) begin ph = P4; m_to = 1; end
          else waits++;
      P3: begin if (!m_wr) begin m_rd = ad_in; m_vld = 1; end ph = P4; end
      default: ph = PI;
    endcase
  endtask

  task automatic compare();
    bit b = (ph != PI);
    bit a = (ph == P2) || (ph == PW) || (ph == P3);
    bit oe = (ph == P1) || (a && m_wr);
    string ct = (ph == P1) ? "R3" : a ? "R4" : "R8";
    chk("R12", "busy", busy, b);
    chk("R3", "ale", ale, ph == P1);
    chk(ct, "rd_n", rd_n, !(a && !m_wr));
    chk(ct, "wr_n", wr_n, !(a && m_wr));
    chk(ct, "den_n", den_n, !a);
    chk(ct, "ad_oe", ad_oe, oe);
    if (oe) chk(ct, "ad_out", ad_out, (ph == P1) ? m_addr[DW-1:0] : m_wd);
    chk("R3", "a_hi", a_hi, b ? m_addr[AW-1:DW] : '0);
    chk("R9", "lat_addr", lat_addr, m_lat);
    chk("R10", "dt_r", dt_r, b ? m_wr : 1'b1);
    chk("R10", "io_m", io_m, b ? m_io : 1'b0);
    chk("R7", "rdata", rdata, m_rd);
    chk("R7", "rdata_vld", rdata_vld, m_vld);
    chk("R11", "timeout", timeout, m_to);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic xfer(input logic w, input logic io, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input int nlow);
    int len = 0, c = 0;
    int exp_len = (nlow > MW) ? MW + 3 : 4 + nlow;
    logic [DW-1:0] rd_before = rdata;
    req = 1; req_wr = w; req_io = io; req_addr = a; req_wdata = d; ready = 1;
    tick();
    while (busy && len < 40) begin
      len++;
      ready = (c >= 1 + nlow);
      req = 1; req_addr = ~a; req_wr = ~w; req_wdata = ~d;
      ad_in = DW'(8'hA0 + c);
      tick();
      c++;
    end
    req = 0;
    chk((nlow == 0) ? "R5" : (nlow > MW) ? "R11" : "R6", "busy length", len, exp_len);
    chk("R2", "address kept", lat_addr, a);
    if (!w && nlow <= MW) chk("R7", "read capture", rdata, DW'(8'hA0 + 2 + nlow));
    else chk("R7", "rdata untouched", rdata, rd_before);
    chk("R11", "abort flag", timeout, nlow > MW);
    tick();
    chk("R12", "idle gap", busy, 1'b0);
  endtask

  initial begin
    repeat (3) tick();
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset strobes", {rd_n, wr_n, den_n, ale, ad_oe}, 5'b11100);
    chk("R1", "reset flags", {rdata_vld, timeout, dt_r, io_m}, 4'b0010);
    chk("R1", "reset a_hi", a_hi, 0);
    chk("R1", "reset data", {lat_addr, rdata}, 0);
    @(negedge clk) rst_n = 1;
    tick();
    xfer(0, 0, 20'h1_2345, 8'h00, 0);
    xfer(1, 1, 20'hF_00A5, 8'h5A, 0);
    xfer(0, 1, 20'hA_BC10, 8'h00, 1);
    xfer(1, 0, 20'h0_7F80, 8'hC3, 3);
    xfer(0, 0, 20'h5_5555, 8'h00, MW);
    xfer(0, 0, 20'hA_AAAA, 8'h00, MW + 1);
    xfer(1, 1, 20'h3_0F0F, 8'h99, 50);
    xfer(0, 0, 20'hF_FFFF, 8'h00, 2);
    for (int i = 0; i < 600; i++) begin
      seed = rnd(seed);
      req = seed[0] | seed[1];
      ready = seed[2] | seed[3];
      if (seed[9:4] == 0) ready = 0;
      req_wr = seed[4]; req_io = seed[5];
      req_addr = seed[31:12]; req_wdata = seed[11:4];
      ad_in = seed[23:16];
      tick();
    end
    req = 0;
    repeat (20) tick();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule